// File: doc/BRIEF.md
# Waveform zero-suppression hit finder

This block sits after the digitizer of one wire channel on a front-end board and turns a continuous stream of samples (one every 0.5 us, 2 MHz) into output records. Three readout styles are selectable at run time: every sample forwarded untouched, windows of samples around threshold crossings, or one compact record per hit carrying the peak amplitude and the time bin where the peak sat. A channel tag travels with every record so that the boards that combine several channels can tell them apart.

An acquisition gate can restrict readout to a fixed stretch after each accelerator spill trigger (8000 bins, i.e. 4 ms). Outside that stretch samples are thrown away and any partly built window or hit is dropped. Records leave through a single output register with a valid/ready handshake. A sticky flag reports any record lost to back-pressure.

Top module: `wfz_hit_finder`

## Requirements
- R1: After reset `out_valid` and `overflow` are 0.
- R2: With `mode` 0 or 3, every accepted sample yields a record on the next cycle: bits [11:0] the sample, bits [15:12] `smp_chan`, bits [31:16] zero.
- R3: With `mode` 1, a sample strictly greater than `thresh` is emitted and arms emission of the 20 samples after it, in the R2 record format. The 21st following sample is not emitted unless it is itself above threshold. A sample equal to `thresh` is not above it.
- R4: With `mode` 1, an above-threshold sample inside an armed window re-arms the full 20-sample count, so that each sample is emitted once at most.
- R5: With `mode` 2, a run of above-threshold samples yields one record when the first sample that is not above threshold arrives, and no record during the run. The record holds the peak bin time in [31:16], the peak value in [15:4] and `smp_chan` in [3:0]. When two samples tie for the peak, the earlier one is kept.
- R6: Bin time counts valid samples. It starts at 0 on the first valid sample after reset or after a `spill_trig` pulse.
- R7: With `spill_only`=1, samples are accepted only during the 8000 valid samples that follow a `spill_trig` pulse. Samples outside that stretch produce no record.
- R8: A window or hit that is still open when the acquisition stretch ends is discarded and never produces a record, including after the next trigger.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold.
- R10: A record produced while the output register holds an unaccepted record is dropped and sets `overflow`, which stays 1 until reset.
- R11: A cycle with `smp_valid`=0 produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Sample value |
| smp_chan | input | 4 | Channel tag within the group |
| thresh | input | 12 | Threshold; above means strictly greater |
| mode | input | 2 | 0/3 raw, 1 window, 2 hit |
| spill_only | input | 1 | Gate readout to the acquisition stretch |
| spill_trig | input | 1 | One-cycle spill trigger pulse |
| out_ready | input | 1 | Consumer accepts the record |
| out_valid | output | 1 | Record present |
| out_data | output | 32 | Record |
| overflow | output | 1 | Sticky record-lost flag |

## Verification
The hit reducer is fed a slow rise with a repeated peak value, a sample exactly at threshold, and a one-sample pulse. These patterns separate strict from inclusive comparison, earliest from latest peak selection, and the bin-time origin. The window mode is run with an isolated crossing and with a crossing inside an armed window. This shows whether the count stops at 20 and whether re-crossing re-arms without duplicating samples. The gated runs put a hit across the end of an 8000-sample stretch and send raw samples at both ends of the stretch, which exposes off-by-one errors in the window length and leaks of hit state past the close.

// File: rtl/wfz_pkg.sv
// Shared mode encoding for the zero-suppression hit finder.
package wfz_pkg;
    typedef enum logic [1:0] {
        MODE_RAW     = 2'd0,
        MODE_WIN     = 2'd1,
        MODE_HIT     = 2'd2,
        MODE_RAW_ALT = 2'd3
    } mode_e;

    // Both raw encodings forward every sample.
    function automatic logic is_raw(input logic [1:0] m);
        return (m == MODE_RAW) || (m == MODE_RAW_ALT);
    endfunction
endpackage

// File: rtl/wfz_spill_gate.sv
// Acquisition gate and bin-time base.
// Assumes spill_trig is a single-cycle pulse. The trigger takes effect for samples
// from the next cycle on. Bin time counts valid samples and restarts at a trigger.
module wfz_spill_gate #(
    parameter int SPILL_BINS = 8000,
    parameter int TIME_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              spill_only,
    input  logic              spill_trig,
    output logic              acq_en,
    output logic [TIME_W-1:0] bin_time
);
    localparam int CNT_W = $clog2(SPILL_BINS + 1);

    logic [CNT_W-1:0] win_left;

    // Remaining samples in the acquisition stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_left <= '0;
        else if (spill_trig)
            win_left <= CNT_W'(SPILL_BINS);
        else if (smp_valid && (win_left != '0))
            win_left <= win_left - CNT_W'(1);
    end

    // Bin counter relative to reset or the last trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bin_time <= '0;
        else if (spill_trig)
            bin_time <= '0;
        else if (smp_valid)
            bin_time <= bin_time + TIME_W'(1);
    end

    // Open when ungated, or while samples remain in the stretch.
    assign acq_en = !spill_only || (win_left != '0);
endmodule

// File: rtl/wfz_dat_window.sv
// Data-above-threshold window. A sample above threshold is emitted and arms
// POST_WIN further samples. A re-crossing re-arms the count. flush clears it.
module wfz_dat_window #(
    parameter int SMP_W    = 12,
    parameter int CHAN_W   = 4,
    parameter int POST_WIN = 20,
    parameter int REC_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [SMP_W-1:0]  thresh,
    output logic              rec_v,
    output logic [REC_W-1:0]  rec_d
);
    localparam int RW = $clog2(POST_WIN + 1);

    logic [RW-1:0] remain;
    logic          above;

    assign above = smp_data > thresh;

    // Count of samples still owed after the latest crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (flush)
            remain <= '0;
        else if (smp_valid) begin
            if (above)
                remain <= RW'(POST_WIN);
            else if (remain != '0)
                remain <= remain - RW'(1);
        end
    end

    // Emit on a crossing or while the window is armed.
    assign rec_v = smp_valid && !flush && (above || (remain != '0));
    assign rec_d = REC_W'({smp_chan, smp_data});
endmodule

// File: rtl/wfz_hit_reducer.sv
// Full-hit reduction. Tracks the peak and its bin during an above-threshold run.
// Emits one record when the run ends. flush abandons an open hit.
module wfz_hit_reducer #(
    parameter int SMP_W  = 12,
    parameter int CHAN_W = 4,
    parameter int TIME_W = 16,
    parameter int REC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [SMP_W-1:0]  thresh,
    input  logic [TIME_W-1:0] bin_time,
    output logic              rec_v,
    output logic [REC_W-1:0]  rec_d
);
    logic              active;
    logic [SMP_W-1:0]  peak;
    logic [TIME_W-1:0] peak_t;
    logic              above;

    assign above = smp_data > thresh;

    // Open-hit flag: set on a crossing, cleared when the run ends or on flush.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (flush)
            active <= 1'b0;
        else if (smp_valid)
            active <= above;
    end

    // Peak value and bin. A strict compare keeps the earliest of equal peaks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak   <= '0;
            peak_t <= '0;
        end else if (!flush && smp_valid && above && (!active || (smp_data > peak))) begin
            peak   <= smp_data;
            peak_t <= bin_time;
        end
    end

    // Record on the first sample that is not above threshold after a run.
    assign rec_v = smp_valid && !flush && active && !above;
    assign rec_d = REC_W'({peak_t, peak, smp_chan});
endmodule

// File: rtl/wfz_out_reg.sv
// One-entry output register with valid/ready.
// A record that arrives while the register is full and stalled is dropped,
// and the drop sets a sticky flag.
module wfz_out_reg #(
    parameter int REC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_v,
    input  logic [REC_W-1:0] rec_d,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [REC_W-1:0] out_data,
    output logic             overflow
);
    logic load;

    assign load = rec_v && (!out_valid || out_ready);

    // Valid flag and payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= rec_d;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Sticky loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (rec_v && out_valid && !out_ready)
            overflow <= 1'b1;
    end
endmodule

// File: rtl/wfz_hit_finder.sv
// Top of the zero-suppression hit finder for one channel stream.
// Selects raw, window or hit readout, applies the spill gate, and drives the
// output register. Assumes the mode changes only between hits; a change flushes
// the state of the mode that is left.
module wfz_hit_finder
    import wfz_pkg::*;
#(
    parameter int SMP_W      = 12,
    parameter int CHAN_W     = 4,
    parameter int TIME_W     = 16,
    parameter int POST_WIN   = 20,
    parameter int SPILL_BINS = 8000,
    parameter int REC_W      = TIME_W + SMP_W + CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [SMP_W-1:0]  thresh,
    input  logic [1:0]        mode,
    input  logic              spill_only,
    input  logic              spill_trig,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [REC_W-1:0]  out_data,
    output logic              overflow
);
    logic              acq_en;
    logic [TIME_W-1:0] bin_time;
    logic              win_v, hit_v, raw_v, sel_v;
    logic [REC_W-1:0]  win_d, hit_d, raw_d, sel_d;
    logic              win_flush, hit_flush;

    wfz_spill_gate #(.SPILL_BINS(SPILL_BINS), .TIME_W(TIME_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .spill_only(spill_only), .spill_trig(spill_trig),
        .acq_en(acq_en), .bin_time(bin_time)
    );

    // Each reducer is flushed when the gate is closed or its mode is not selected.
    assign win_flush = !acq_en || (mode != MODE_WIN);
    assign hit_flush = !acq_en || (mode != MODE_HIT);

    wfz_dat_window #(.SMP_W(SMP_W), .CHAN_W(CHAN_W), .POST_WIN(POST_WIN), .REC_W(REC_W)) u_win (
        .clk(clk), .rst_n(rst_n), .flush(win_flush), .smp_valid(smp_valid),
        .smp_data(smp_data), .smp_chan(smp_chan), .thresh(thresh),
        .rec_v(win_v), .rec_d(win_d)
    );

    wfz_hit_reducer #(.SMP_W(SMP_W), .CHAN_W(CHAN_W), .TIME_W(TIME_W), .REC_W(REC_W)) u_hit (
        .clk(clk), .rst_n(rst_n), .flush(hit_flush), .smp_valid(smp_valid),
        .smp_data(smp_data), .smp_chan(smp_chan), .thresh(thresh),
        .bin_time(bin_time), .rec_v(hit_v), .rec_d(hit_d)
    );

    // Raw path: every gated sample, tagged with its channel.
    assign raw_v = smp_valid && acq_en && is_raw(mode);
    assign raw_d = REC_W'({smp_chan, smp_data});

    // Record select by mode.
    always_comb begin
        sel_v = raw_v;
        sel_d = raw_d;
        if (mode == MODE_WIN) begin
            sel_v = win_v;
            sel_d = win_d;
        end else if (mode == MODE_HIT) begin
            sel_v = hit_v;
            sel_d = hit_d;
        end
    end

    wfz_out_reg #(.REC_W(REC_W)) u_out (
        .clk(clk), .rst_n(rst_n), .rec_v(sel_v), .rec_d(sel_d),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .overflow(overflow)
    );
endmodule

// File: rtl/wfz_hit_finder_chk.sv
// Assertion checker for wfz_hit_finder, bound into every instance.
module wfz_hit_finder_chk #(
    parameter int SMP_W  = 12,
    parameter int CHAN_W = 4,
    parameter int REC_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [SMP_W-1:0]  smp_data,
    input logic [CHAN_W-1:0] smp_chan,
    input logic [1:0]        mode,
    input logic              acq_en,
    input logic              out_ready,
    input logic              out_valid,
    input logic [REC_W-1:0]  out_data,
    input logic              overflow
);
    // R9: a stalled record holds.
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: the loss flag never clears without reset.
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R7: nothing new appears while the gate is closed.
    assert_gate_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_en && !out_valid) |=> !out_valid);

    // R11: no record without a sample.
    assert_no_sample_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !out_valid) |=> !out_valid);

    // R2: a raw sample that can be loaded appears next cycle with its tag.
    assert_raw_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && acq_en && (mode == 2'd0 || mode == 2'd3) && (!out_valid || out_ready))
        |=> (out_valid && out_data[SMP_W-1:0] == $past(smp_data)
             && out_data[SMP_W+CHAN_W-1:SMP_W] == $past(smp_chan)));
endmodule

bind wfz_hit_finder wfz_hit_finder_chk #(.SMP_W(SMP_W), .CHAN_W(CHAN_W), .REC_W(REC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_chan(smp_chan), .mode(mode), .acq_en(acq_en), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow)
);

// File: tb/sim_wfz_hit_finder.sv
// Self-checking bench for wfz_hit_finder: a vector table, then directed tests.
module sim_wfz_hit_finder;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    localparam int WDOG = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic [3:0]  smp_chan = 4'd5;
    logic [11:0] thresh = 12'd100;
    logic [1:0]  mode = 2'd2;
    logic        spill_only = 1'b0;
    logic        spill_trig = 1'b0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [31:0] out_data;
    logic        overflow;

    int n_chk = 0;
    int n_bad = 0;

    // Row: mode[47:46] valid[45] sample[44:33] exp_valid[32] exp_data[31:0]
    localparam logic [47:0] TBL [0:NV-1] = '{
        {2'd2, 1'b1, 12'd50,   1'b0, 32'd0},
        {2'd2, 1'b1, 12'd120,  1'b0, 32'd0},
        {2'd2, 1'b1, 12'd200,  1'b0, 32'd0},
        {2'd2, 1'b1, 12'd150,  1'b0, 32'd0},
        {2'd2, 1'b1, 12'd200,  1'b0, 32'd0},
        {2'd2, 1'b1, 12'd90,   1'b1, {16'd2, 12'd200, 4'd5}},
        {2'd2, 1'b1, 12'd100,  1'b0, 32'd0},
        {2'd2, 1'b1, 12'd101,  1'b0, 32'd0},
        {2'd2, 1'b1, 12'd0,    1'b1, {16'd7, 12'd101, 4'd5}},
        {2'd0, 1'b1, 12'd77,   1'b1, {16'd0, 4'd5, 12'd77}},
        {2'd3, 1'b1, 12'd4095, 1'b1, {16'd0, 4'd5, 12'd4095}},
        {2'd0, 1'b0, 12'd33,   1'b0, 32'd0}
    };

    wfz_hit_finder u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_chan(smp_chan), .thresh(thresh), .mode(mode), .spill_only(spill_only),
        .spill_trig(spill_trig), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .overflow(overflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle from a falling edge; return at the next falling edge.
    task automatic push(input logic v, input logic [11:0] d);
        smp_valid = v;
        smp_data  = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic trig();
        spill_trig = 1'b1;
        push(1'b0, 12'd0);
        spill_trig = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_rec(input string tag, input logic [31:0] d);
        check(tag, {31'd0, out_valid}, 32'd1);
        check(tag, out_data, d);
    endtask

    initial begin
        #(CLK_PERIOD * WDOG);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 overflow after reset", {31'd0, overflow}, 32'd0);

        // Vector table: hit mode with continuous time base, then raw mode and idle.
        for (int i = 0; i < NV; i++) begin
            mode = TBL[i][47:46];
            push(TBL[i][45], TBL[i][44:33]);
            if (TBL[i][47:46] == 2'd2)
                check($sformatf("R5 R6 row %0d valid", i), {31'd0, out_valid}, {31'd0, TBL[i][32]});
            else if (TBL[i][45])
                check($sformatf("R2 row %0d valid", i), {31'd0, out_valid}, {31'd0, TBL[i][32]});
            else
                check($sformatf("R11 row %0d valid", i), {31'd0, out_valid}, {31'd0, TBL[i][32]});
            if (TBL[i][32])
                check($sformatf("R5 R2 row %0d data", i), out_data, TBL[i][31:0]);
        end

        // R3: an isolated crossing plus 20 samples, nothing on the 21st.
        do_reset();
        mode = 2'd1;
        push(1'b1, 12'd50);
        check("R3 below threshold", {31'd0, out_valid}, 32'd0);
        push(1'b1, 12'd150);
        expect_rec("R3 crossing", {16'd0, 4'd5, 12'd150});
        for (int k = 0; k < 20; k++) begin
            push(1'b1, 12'd10);
            expect_rec("R3 window sample", {16'd0, 4'd5, 12'd10});
        end
        push(1'b1, 12'd10);
        check("R3 after window", {31'd0, out_valid}, 32'd0);

        // R4: a re-crossing at 5 re-arms the full window.
        push(1'b1, 12'd150);
        expect_rec("R4 first crossing", {16'd0, 4'd5, 12'd150});
        for (int k = 0; k < 5; k++) begin
            push(1'b1, 12'd10);
            expect_rec("R4 early sample", {16'd0, 4'd5, 12'd10});
        end
        push(1'b1, 12'd160);
        expect_rec("R4 re-crossing", {16'd0, 4'd5, 12'd160});
        for (int k = 0; k < 20; k++) begin
            push(1'b1, 12'd11);
            expect_rec("R4 extended sample", {16'd0, 4'd5, 12'd11});
        end
        push(1'b1, 12'd11);
        check("R4 extended end", {31'd0, out_valid}, 32'd0);

        // R7: raw samples gated to the 8000-sample stretch.
        do_reset();
        mode = 2'd0;
        spill_only = 1'b1;
        push(1'b1, 12'd5);
        check("R7 before trigger", {31'd0, out_valid}, 32'd0);
        trig();
        push(1'b1, 12'd7);
        expect_rec("R7 first in window", {16'd0, 4'd5, 12'd7});
        for (int k = 1; k < 7999; k++) push(1'b1, 12'd1);
        push(1'b1, 12'd9);
        expect_rec("R7 last in window", {16'd0, 4'd5, 12'd9});
        push(1'b1, 12'd3);
        check("R7 after window", {31'd0, out_valid}, 32'd0);

        // R6: hit time counts from the trigger.
        mode = 2'd2;
        trig();
        push(1'b1, 12'd10);
        push(1'b1, 12'd10);
        push(1'b1, 12'd150);
        push(1'b1, 12'd20);
        expect_rec("R6 bin after trigger", {16'd2, 12'd150, 4'd5});

        // R8: a hit open at the end of the stretch is discarded.
        trig();
        for (int k = 0; k < 7997; k++) push(1'b1, 12'd0);
        push(1'b1, 12'd150);
        push(1'b1, 12'd200);
        push(1'b1, 12'd210);
        push(1'b1, 12'd0);
        check("R8 closed at window end", {31'd0, out_valid}, 32'd0);
        trig();
        push(1'b1, 12'd0);
        check("R8 no stale hit after retrigger", {31'd0, out_valid}, 32'd0);

        // R9, R10: back-pressure holds the record and sets the flag.
        do_reset();
        spill_only = 1'b0;
        mode = 2'd0;
        out_ready = 1'b0;
        push(1'b1, 12'd1);
        expect_rec("R9 first record", {16'd0, 4'd5, 12'd1});
        check("R10 no loss yet", {31'd0, overflow}, 32'd0);
        push(1'b1, 12'd2);
        expect_rec("R9 held under stall", {16'd0, 4'd5, 12'd1});
        check("R10 loss flagged", {31'd0, overflow}, 32'd1);
        out_ready = 1'b1;
        push(1'b0, 12'd0);
        check("R9 drained", {31'd0, out_valid}, 32'd0);
        check("R10 flag sticky", {31'd0, overflow}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule